// File: doc/BRIEF.md
# Sensor Output Conditioner: Self-Test Override, Two-Sample Filter and Change Interrupt

This block sits between a bank of comparator outputs and the register that software reads. Each comparator bit first passes through a two-flop synchroniser.

A self-test control can replace every comparator result with the matching configuration bit. Software can then write a pattern, read the conditioned bits back and compare the two.

An optional filter, chosen by an enable input, samples the selected bits once per sample period. It accepts a new level on a channel only when two samples in a row agree on it. With the filter off, the conditioned bits follow the selected bits after a fixed register delay.

When a conditioned bit changes, the block raises a drive-enable for an open-drain, active-low interrupt line for a fixed number of cycles. The first change after reset is not reported. A change that comes while a pulse is active restarts the pulse, so changes close together merge into one pulse. The sample period and the pulse width are parameters given in clock cycles.

Top module: `sensor_cond`

## Requirements
- R1: While reset is high and on the first edge after it, sense_o is all zeros and int_oe_o is 0, whatever raw_i is.
- R2: With test_en_i and dbnc_en_i low, a change on raw_i appears on sense_o on the third rising clock edge after it is applied (two synchroniser flops plus the output register) and not before.
- R3: With test_en_i high and dbnc_en_i low, sense_o equals cfg_i one clock edge after cfg_i is applied, and a change of raw_i has no effect on sense_o.
- R4: With dbnc_en_i high, sense_o changes only on a sample tick. A new level is accepted only when two consecutive samples, SAMPLE_CYC cycles apart, agree, so it takes at least SAMPLE_CYC+2 edges after the raw change.
- R5: With dbnc_en_i high, a raw pulse shorter than SAMPLE_CYC cycles never reaches sense_o and raises no interrupt.
- R6: With dbnc_en_i high, a steady new raw level reaches sense_o within 2*SAMPLE_CYC+3 edges.
- R7: Any change of sense_o, other than the first after reset, drives int_oe_o high from the next edge for exactly PULSE_CYC cycles.
- R8: A change of sense_o while int_oe_o is high gives no second rising edge of int_oe_o. The pulse restarts and ends PULSE_CYC cycles after that change is detected.
- R9: The first change of sense_o after reset raises no interrupt pulse.
- R10: Bit i of sense_o is conditioned from bit i of raw_i and bit i of cfg_i. Bit 0 is channel 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_i | input | NCH | Asynchronous comparator results, bit 0 = channel 1 |
| test_en_i | input | 1 | Self-test: replace comparator results with cfg_i |
| cfg_i | input | NCH | Per-channel configuration bits, used as forced values in self-test |
| dbnc_en_i | input | 1 | Enables the two-sample filter (low by default at board level) |
| sense_o | output | NCH | Conditioned sensor bits |
| int_oe_o | output | 1 | Drive-enable for the active-low open-drain interrupt line |

## Verification
The bench builds the block with SAMPLE_CYC = 16 and PULSE_CYC = 8. With those values, the filter's one-period and two-period windows are short enough to bound the acceptance latency from both sides and to show a 3-cycle glitch being rejected. The short pulse lets the bench count exact pulse widths, merge two changes two cycles apart, and restart a pulse six cycles into it, all in a few dozen cycles. The register latency of the unfiltered path and the self-test path is checked edge by edge.

// File: rtl/sensor_cond_pkg.sv
package sensor_cond_pkg;
  // depth of the input synchroniser chain
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = sensor_cond_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sc_debounce.sv
module sc_debounce #(
  parameter int unsigned W          = 8,
  parameter int unsigned SAMPLE_CYC = 7_500_000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned CW = (SAMPLE_CYC > 1) ? $clog2(SAMPLE_CYC) : 1;
  localparam logic [CW-1:0] LIM = CW'(SAMPLE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  for (genvar ch = 0; ch < W; ch++) begin : g_ch
    logic smp_q;
    logic out_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        smp_q <= 1'b0;
        out_q <= 1'b0;
      end else begin
        if (tick) smp_q <= d_i[ch];
        if (!en_i) out_q <= d_i[ch];
        else if (tick && (d_i[ch] == smp_q)) out_q <= d_i[ch];
      end
    end
    assign q_o[ch] = out_q;
  end

  // R4
  stable_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && !tick) |=> $stable(q_o));
endmodule

// File: rtl/sc_irq.sv
module sc_irq #(
  parameter int unsigned W         = 8,
  parameter int unsigned PULSE_CYC = 125
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic         oe_o
);
  localparam int unsigned PW = $clog2(PULSE_CYC + 1);
  localparam logic [PW-1:0] PLOAD = PW'(PULSE_CYC);

  logic [W-1:0]  prev_q;
  logic          seen_q;
  logic [PW-1:0] pcnt_q;
  logic          oe_q;
  logic          chg;

  assign chg = (d_i != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      seen_q <= 1'b0;
      pcnt_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      prev_q <= d_i;
      if (chg) seen_q <= 1'b1;
      if (chg && seen_q) begin
        pcnt_q <= PLOAD;
        oe_q   <= 1'b1;
      end else if (pcnt_q == PW'(1)) begin
        pcnt_q <= '0;
        oe_q   <= 1'b0;
      end else if (pcnt_q != '0) begin
        pcnt_q <= pcnt_q - 1'b1;
      end
    end
  end

  assign oe_o = oe_q;

  // R8
  rise_needs_change_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_o) |-> $past(d_i) != $past(d_i, 2));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !oe_o);
endmodule

// File: rtl/sensor_cond.sv
module sensor_cond #(
  parameter int unsigned NCH        = 8,
  parameter int unsigned SAMPLE_CYC = 7_500_000,
  parameter int unsigned PULSE_CYC  = 125
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] raw_i,
  input  logic           test_en_i,
  input  logic [NCH-1:0] cfg_i,
  input  logic           dbnc_en_i,
  output logic [NCH-1:0] sense_o,
  output logic           int_oe_o
);
  logic [NCH-1:0] raw_s;
  logic [NCH-1:0] sel;

  sc_sync #(.W(NCH)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_i), .q_o(raw_s)
  );

  assign sel = test_en_i ? cfg_i : raw_s;

  sc_debounce #(.W(NCH), .SAMPLE_CYC(SAMPLE_CYC)) u_dbnc (
    .clk(clk), .rst(rst), .en_i(dbnc_en_i), .d_i(sel), .q_o(sense_o)
  );

  sc_irq #(.W(NCH), .PULSE_CYC(PULSE_CYC)) u_irq (
    .clk(clk), .rst(rst), .d_i(sense_o), .oe_o(int_oe_o)
  );

  // R3
  selftest_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (test_en_i && !dbnc_en_i) |=> sense_o == $past(cfg_i));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> sense_o == '0);
endmodule

// File: tb/sim_sensor_cond.sv
module sim_sensor_cond;
  localparam int S = 16;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] raw = '0;
  logic       test_en = 1'b0;
  logic [7:0] cfg = '0;
  logic       dbnc = 1'b0;
  logic [7:0] sense;
  logic       oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sensor_cond #(.NCH(8), .SAMPLE_CYC(S), .PULSE_CYC(P)) u0 (
    .clk(clk), .rst(rst), .raw_i(raw), .test_en_i(test_en), .cfg_i(cfg),
    .dbnc_en_i(dbnc), .sense_o(sense), .int_oe_o(oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic count_high(input int win, output int hi, output int rises);
    logic prev;
    prev = oe;
    hi = 0;
    rises = 0;
    for (int i = 0; i < win; i++) begin
      step();
      if (oe) hi++;
      if (oe && !prev) rises++;
      prev = oe;
    end
  endtask

  task automatic t_reset();
    raw = 8'hFF;
    step(3);
    chk(sense == 8'h00, "R1 sense in reset", sense, 0);
    chk(oe == 1'b0, "R1 int in reset", oe, 0);
    raw = 8'h00;
    step(3);
    rst = 1'b0;
    step();
    chk(sense == 8'h00 && oe == 1'b0, "R1 after release", {oe, sense}, 0);
  endtask

  task automatic t_first_no_irq();
    int hi, rises;
    raw = 8'h01;
    step(3);
    chk(sense == 8'h01, "R10 channel 1 on bit 0", sense, 8'h01);
    count_high(15, hi, rises);
    chk(hi == 0, "R9 no pulse on first change", hi, 0);
  endtask

  task automatic t_follow();
    int hi, rises;
    raw = 8'h81;
    step(2);
    chk(sense == 8'h01, "R2 unchanged after 2 edges", sense, 8'h01);
    step();
    chk(sense == 8'h81, "R2 new value at 3rd edge", sense, 8'h81);
    chk(oe == 1'b0, "R7 int not yet", oe, 0);
    step();
    chk(oe == 1'b1, "R7 int on next edge", oe, 1);
    hi = 1;
    for (int i = 0; i < 40 && oe; i++) begin
      step();
      if (oe) hi++;
    end
    chk(hi == P, "R7 pulse width", hi, P);
    step(4);
  endtask

  task automatic t_patterns();
    logic [7:0] pats [3] = '{8'h5A, 8'hC3, 8'h00};
    for (int k = 0; k < 3; k++) begin
      raw = pats[k];
      step(3);
      chk(sense == pats[k], "R2 pattern", sense, pats[k]);
      step(P + 4);
    end
  endtask

  task automatic t_merge();
    int hi, rises;
    raw = 8'h02;
    step(2);
    raw = 8'h06;
    count_high(30, hi, rises);
    chk(rises == 1, "R8 merged into one pulse", rises, 1);
    chk(hi == P + 2, "R8 merged pulse length", hi, P + 2);
  endtask

  task automatic t_restart();
    int hi, rises;
    raw = 8'h07;
    step(6);
    chk(oe == 1'b1, "R7 pulse active", oe, 1);
    raw = 8'h0F;
    count_high(30, hi, rises);
    chk(rises == 0, "R8 no second rise", rises, 0);
    chk(hi == P + 3, "R8 restarted pulse tail", hi, P + 3);
  endtask

  task automatic t_selftest();
    int hi, rises;
    cfg = 8'hA5;
    test_en = 1'b1;
    step();
    chk(sense == 8'hA5, "R3 forced to cfg", sense, 8'hA5);
    raw = 8'hF0;
    step(5);
    chk(sense == 8'hA5, "R3 raw ignored", sense, 8'hA5);
    cfg = 8'h3C;
    step();
    chk(sense == 8'h3C, "R3 new cfg", sense, 8'h3C);
    test_en = 1'b0;
    step();
    chk(sense == 8'hF0, "R3 back to raw", sense, 8'hF0);
    step(P + 4);
  endtask

  task automatic t_debounce();
    int n, hi, rises;
    dbnc = 1'b1;
    step(2 * S + 2);
    chk(sense == 8'hF0, "R4 steady level kept", sense, 8'hF0);
    raw = 8'hD0;
    n = 0;
    while (sense != 8'hD0 && n < 200) begin
      step();
      n++;
    end
    chk(n >= S + 2, "R4 needs two samples", n, S + 2);
    chk(n <= 2 * S + 3, "R6 accepted in time", n, 2 * S + 3);
    step(P + 4);
    raw = 8'hD2;
    step(3);
    raw = 8'hD0;
    count_high(3 * S, hi, rises);
    chk(sense == 8'hD0, "R5 glitch rejected", sense, 8'hD0);
    chk(hi == 0, "R5 no interrupt from glitch", hi, 0);
    dbnc = 1'b0;
    step(4);
  endtask

  initial begin
    t_reset();
    t_first_no_irq();
    t_follow();
    t_patterns();
    t_merge();
    t_restart();
    t_selftest();
    t_debounce();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule